// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a small 8-bit core built around a single accumulator. Each cycle with `in_valid` high it takes one 14-bit instruction word, the byte already read from the register the instruction names, the current accumulator value and the current carry flag. It decodes the instruction and performs the arithmetic, logic, rotate, nibble-swap, increment/decrement, bit set/clear or bit-test operation. One cycle later it presents the result together with a write enable for either the accumulator or the named register.

It also presents new carry, digit-carry and zero flag values, each with its own update enable, and a request to turn the next fetched instruction into a bubble. Instructions that belong to other parts of the core (return-with-literal, sleep, watchdog clear, timer-mode load and port-direction load) leave this block only as one-cycle strobes.

The instruction word has a two-bit class field in bits 13:12. Class 01 holds register operations, with the operation in bits 11:8, the destination bit in bit 7 and the register address in bits 6:0. Class 11 holds bit operations, with the operation in bits 11:10, the bit index in bits 9:7 and the address in bits 6:0. Class 00 holds immediate operations, with the operation in bits 11:8 and the literal in bits 7:0. Class 10 is not handled here.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous active-high reset forces every output to zero, whatever the inputs. This also holds when reset is asserted in the middle of a run.
- R2: In class 01 (except the clear/special rows), bit 7 = 0 sends the result to the accumulator (`acc_we`) and bit 7 = 1 sends it to the register (`reg_we`). The two enables are never high together.
- R3: Operation code 1010 (subtract) yields register minus accumulator. `c_out`=1 means no borrow and `dc_out`=1 means no borrow out of the low nibble. Zero is flagged, and all three flag enables are high.
- R4: Operation code 0101 (add) yields register plus accumulator. The carry comes out of bit 7 and the digit carry out of bit 3; the zero flag and all three flag enables are high. Only add and subtract ever raise `dc_we`.
- R5: AND (0100), XOR (1011), OR (1111), complement (0010), move-register (0011), increment (1000) and decrement (0110) update only the zero flag. Nibble swap (1110) updates no flag.
- R6: Rotate right (1100) gives {carry_in, R[7:1]} with carry = R[0]. Rotate left (1101) gives {R[6:0], carry_in} with carry = R[7]. Only the carry enable is raised.
- R7: Increment-and-skip (1001) and decrement-and-skip (0111) write the result but update no flag. They raise `skip_req` exactly when the result is zero.
- R8: Bit operations in class 11: code 10 sets bit b of the register and code 11 clears it, both writing to the register. Code 00 skips when bit b is 1 and code 01 skips when it is 0, without writing. None touches a flag.
- R9: Immediate operations target only the accumulator and ignore `reg_val`. 1001 ANDs, 1000 XORs and 0011 ORs the literal with the accumulator and update zero. 0001 loads the literal with no flag. 1100 loads the literal and pulses `ret_pulse`.
- R10: 01 0001 0 0000000 clears the accumulator and 01 0001 1 rrrrrrr clears the register; both set zero with its enable. 01 0000 1 rrrrrrr copies the accumulator into the register with no flag.
- R11: With bits 13:7 = 01 0000 0, low bits 0 are a no-op. Low bits 1 pulse `wdt_clr_pulse` and 2 pulse `sleep_pulse`. Low bits 3 pulse `mode_ld_pulse` and 5, 6 or 7 pulse `dir_ld_pulse`, with the accumulator on `result` for the two loads. None of these writes or skips.
- R12: Every other encoding, including all of class 10, raises no write enable, no flag enable, no strobe and no skip, and drives `result` to zero. A flag value output is zero whenever its enable is low.
- R13: All outputs are registered one cycle after the instruction is presented. A cycle with `in_valid` low produces all-zero outputs on the next cycle, so the skip request is a one-cycle pulse per instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 14 | Instruction word |
| reg_val | input | 8 | Byte read from the addressed register |
| acc_val | input | 8 | Current accumulator value |
| carry_in | input | 1 | Current carry flag, used by the rotates |
| result | output | 8 | Value to be written back |
| acc_we | output | 1 | Write `result` into the accumulator |
| reg_we | output | 1 | Write `result` into the addressed register |
| c_out | output | 1 | New carry flag |
| dc_out | output | 1 | New digit-carry flag |
| z_out | output | 1 | New zero flag |
| c_we | output | 1 | Update the carry flag |
| dc_we | output | 1 | Update the digit-carry flag |
| z_we | output | 1 | Update the zero flag |
| skip_req | output | 1 | Replace the next instruction with a bubble |
| ret_pulse | output | 1 | Return-with-literal strobe |
| sleep_pulse | output | 1 | Sleep strobe |
| wdt_clr_pulse | output | 1 | Watchdog clear strobe |
| mode_ld_pulse | output | 1 | Timer-mode load strobe, data on `result` |
| dir_ld_pulse | output | 1 | Port-direction load strobe, data on `result` |

## Verification
A write-back and a skip request can both land in the same cycle. This happens when increment-and-skip or decrement-and-skip reaches zero: the unit must raise `reg_we` or `acc_we` and `skip_req` together while every flag enable stays low. The bench provokes it with operands of 0xFF and 0x01 under both destination settings, and compares the whole output word in that one cycle. It then drops `in_valid` to confirm the skip falls after a single cycle, and pairs this with bit tests that must skip without writing at all.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  localparam int DATA_W  = 8;
  localparam int INSTR_W = 14;
  localparam int IDX_W   = $clog2(DATA_W);

  typedef enum logic [4:0] {
    ALU_NONE  = 5'd0,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_IOR,
    ALU_XOR,
    ALU_COM,
    ALU_MOVX,
    ALU_PASSA,
    ALU_INC,
    ALU_DEC,
    ALU_RR,
    ALU_RL,
    ALU_SWAP,
    ALU_CLR,
    ALU_BSET,
    ALU_BCLR
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             imm_src;
    logic             wr_acc;
    logic             wr_reg;
    logic             upd_c;
    logic             upd_dc;
    logic             upd_z;
    logic             skip_zero;
    logic             skip_bset;
    logic             skip_bclr;
    logic [IDX_W-1:0] bit_idx;
    logic             st_ret;
    logic             st_sleep;
    logic             st_wdt;
    logic             st_mode;
    logic             st_dir;
  } dec_t;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
#(
  parameter int INSTR_W_P = INSTR_W
) (
  input  logic [INSTR_W_P-1:0] instr,
  output dec_t                 dec
);

  logic [1:0] cls;
  logic [3:0] rop;
  logic       dbit;
  logic [6:0] low7;
  logic [1:0] bop;

  assign cls  = instr[13:12];
  assign rop  = instr[11:8];
  assign dbit = instr[7];
  assign low7 = instr[6:0];
  assign bop  = instr[11:10];

  always_comb begin
    dec         = '0;
    dec.op      = ALU_NONE;
    dec.bit_idx = instr[9:7];
    unique case (cls)
      2'b01: begin
        unique case (rop)
          4'b0000: begin
            if (dbit) begin
              dec.op     = ALU_PASSA;
              dec.wr_reg = 1'b1;
            end else begin
              unique case (low7)
                7'd1: dec.st_wdt   = 1'b1;
                7'd2: dec.st_sleep = 1'b1;
                7'd3: begin
                  dec.op      = ALU_PASSA;
                  dec.st_mode = 1'b1;
                end
                7'd5, 7'd6, 7'd7: begin
                  dec.op     = ALU_PASSA;
                  dec.st_dir = 1'b1;
                end
                default: dec.op = ALU_NONE;
              endcase
            end
          end
          4'b0001: begin
            if (dbit) begin
              dec.op     = ALU_CLR;
              dec.wr_reg = 1'b1;
              dec.upd_z  = 1'b1;
            end else if (low7 == 7'd0) begin
              dec.op     = ALU_CLR;
              dec.wr_acc = 1'b1;
              dec.upd_z  = 1'b1;
            end
          end
          default: begin
            dec.wr_acc = ~dbit;
            dec.wr_reg = dbit;
            unique case (rop)
              4'b0010: begin dec.op = ALU_COM;  dec.upd_z = 1'b1; end
              4'b0011: begin dec.op = ALU_MOVX; dec.upd_z = 1'b1; end
              4'b0100: begin dec.op = ALU_AND;  dec.upd_z = 1'b1; end
              4'b0101: begin
                dec.op     = ALU_ADD;
                dec.upd_c  = 1'b1;
                dec.upd_dc = 1'b1;
                dec.upd_z  = 1'b1;
              end
              4'b0110: begin dec.op = ALU_DEC;  dec.upd_z = 1'b1; end
              4'b0111: begin dec.op = ALU_DEC;  dec.skip_zero = 1'b1; end
              4'b1000: begin dec.op = ALU_INC;  dec.upd_z = 1'b1; end
              4'b1001: begin dec.op = ALU_INC;  dec.skip_zero = 1'b1; end
              4'b1010: begin
                dec.op     = ALU_SUB;
                dec.upd_c  = 1'b1;
                dec.upd_dc = 1'b1;
                dec.upd_z  = 1'b1;
              end
              4'b1011: begin dec.op = ALU_XOR;  dec.upd_z = 1'b1; end
              4'b1100: begin dec.op = ALU_RR;   dec.upd_c = 1'b1; end
              4'b1101: begin dec.op = ALU_RL;   dec.upd_c = 1'b1; end
              4'b1110: begin dec.op = ALU_SWAP; end
              default: begin dec.op = ALU_IOR;  dec.upd_z = 1'b1; end
            endcase
          end
        endcase
      end
      2'b11: begin
        unique case (bop)
          2'b00: dec.skip_bset = 1'b1;
          2'b01: dec.skip_bclr = 1'b1;
          2'b10: begin dec.op = ALU_BSET; dec.wr_reg = 1'b1; end
          default: begin dec.op = ALU_BCLR; dec.wr_reg = 1'b1; end
        endcase
      end
      2'b00: begin
        dec.imm_src = 1'b1;
        unique case (rop)
          4'b1001: begin dec.op = ALU_AND;   dec.wr_acc = 1'b1; dec.upd_z = 1'b1; end
          4'b1000: begin dec.op = ALU_XOR;   dec.wr_acc = 1'b1; dec.upd_z = 1'b1; end
          4'b0011: begin dec.op = ALU_IOR;   dec.wr_acc = 1'b1; dec.upd_z = 1'b1; end
          4'b0001: begin dec.op = ALU_PASSA; dec.wr_acc = 1'b1; end
          4'b1100: begin dec.op = ALU_PASSA; dec.wr_acc = 1'b1; dec.st_ret = 1'b1; end
          default: dec.imm_src = 1'b0;
        endcase
      end
      default: dec.op = ALU_NONE;
    endcase
  end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e                  op,
  input  logic [W-1:0]             x,
  input  logic [W-1:0]             a,
  input  logic                     cin,
  input  logic [$clog2(W)-1:0]     bit_idx,
  output logic [W-1:0]             res,
  output logic                     c,
  output logic                     dc,
  output logic                     bit_val
);

  localparam int H  = W / 2;
  localparam int IW = $clog2(W);

  logic [W-1:0] bmask;
  logic [W:0]   add_full, sub_full;
  logic [H:0]   lo_add, lo_sub;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign bmask[i] = (bit_idx == IW'(i));
  end

  assign add_full = {1'b0, x} + {1'b0, a};
  assign sub_full = {1'b0, x} + {1'b0, ~a} + {{W{1'b0}}, 1'b1};
  assign lo_add   = {1'b0, x[H-1:0]} + {1'b0, a[H-1:0]};
  assign lo_sub   = {1'b0, x[H-1:0]} + {1'b0, ~a[H-1:0]} + {{H{1'b0}}, 1'b1};
  assign bit_val  = |(x & bmask);

  always_comb begin
    res = '0;
    c   = 1'b0;
    dc  = 1'b0;
    unique case (op)
      ALU_ADD:   begin res = add_full[W-1:0]; c = add_full[W]; dc = lo_add[H]; end
      ALU_SUB:   begin res = sub_full[W-1:0]; c = sub_full[W]; dc = lo_sub[H]; end
      ALU_AND:   res = x & a;
      ALU_IOR:   res = x | a;
      ALU_XOR:   res = x ^ a;
      ALU_COM:   res = ~x;
      ALU_MOVX:  res = x;
      ALU_PASSA: res = a;
      ALU_INC:   res = x + W'(1);
      ALU_DEC:   res = x - W'(1);
      ALU_RR:    begin res = {cin, x[W-1:1]}; c = x[0]; end
      ALU_RL:    begin res = {x[W-2:0], cin}; c = x[W-1]; end
      ALU_SWAP:  res = {x[H-1:0], x[W-1:H]};
      ALU_BSET:  res = x | bmask;
      ALU_BCLR:  res = x & ~bmask;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W_P  = DATA_W,
  parameter int INSTR_W_P = INSTR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W_P-1:0] instr,
  input  logic [DATA_W_P-1:0]  reg_val,
  input  logic [DATA_W_P-1:0]  acc_val,
  input  logic                 carry_in,
  output logic [DATA_W_P-1:0]  result,
  output logic                 acc_we,
  output logic                 reg_we,
  output logic                 c_out,
  output logic                 dc_out,
  output logic                 z_out,
  output logic                 c_we,
  output logic                 dc_we,
  output logic                 z_we,
  output logic                 skip_req,
  output logic                 ret_pulse,
  output logic                 sleep_pulse,
  output logic                 wdt_clr_pulse,
  output logic                 mode_ld_pulse,
  output logic                 dir_ld_pulse
);

  dec_t                dec;
  logic [DATA_W_P-1:0] x_opnd, a_opnd, alu_res;
  logic                alu_c, alu_dc, alu_bit, alu_zero;
  logic                keep_res, skip_nxt;

  acc_exec_decode #(.INSTR_W_P(INSTR_W_P)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign x_opnd = dec.imm_src ? acc_val : reg_val;
  assign a_opnd = dec.imm_src ? instr[DATA_W_P-1:0] : acc_val;

  acc_exec_alu #(.W(DATA_W_P)) u_alu (
    .op      (dec.op),
    .x       (x_opnd),
    .a       (a_opnd),
    .cin     (carry_in),
    .bit_idx (dec.bit_idx),
    .res     (alu_res),
    .c       (alu_c),
    .dc      (alu_dc),
    .bit_val (alu_bit)
  );

  assign alu_zero = (alu_res == '0);
  assign keep_res = dec.wr_acc | dec.wr_reg | dec.st_mode | dec.st_dir;
  assign skip_nxt = (dec.skip_zero & alu_zero) | (dec.skip_bset & alu_bit) |
                    (dec.skip_bclr & ~alu_bit);

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      result        <= '0;
      acc_we        <= 1'b0;
      reg_we        <= 1'b0;
      c_out         <= 1'b0;
      dc_out        <= 1'b0;
      z_out         <= 1'b0;
      c_we          <= 1'b0;
      dc_we         <= 1'b0;
      z_we          <= 1'b0;
      skip_req      <= 1'b0;
      ret_pulse     <= 1'b0;
      sleep_pulse   <= 1'b0;
      wdt_clr_pulse <= 1'b0;
      mode_ld_pulse <= 1'b0;
      dir_ld_pulse  <= 1'b0;
    end else begin
      result        <= keep_res ? alu_res : '0;
      acc_we        <= dec.wr_acc;
      reg_we        <= dec.wr_reg;
      c_out         <= dec.upd_c & alu_c;
      dc_out        <= dec.upd_dc & alu_dc;
      z_out         <= dec.upd_z & alu_zero;
      c_we          <= dec.upd_c;
      dc_we         <= dec.upd_dc;
      z_we          <= dec.upd_z;
      skip_req      <= skip_nxt;
      ret_pulse     <= dec.st_ret;
      sleep_pulse   <= dec.st_sleep;
      wdt_clr_pulse <= dec.st_wdt;
      mode_ld_pulse <= dec.st_mode;
      dir_ld_pulse  <= dec.st_dir;
    end
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst) !(acc_we && reg_we)); // R2
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[13:8] == 6'b011010) |=>
      (c_we && dc_we && (c_out == ($past(reg_val) >= $past(acc_val))))); // R3
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[13:8] == 6'b010101) |=>
      (c_we && (c_out == ($past(reg_val) > ~$past(acc_val))))); // R4
  AST_DC_ARITH_ONLY: assert property (@(posedge clk) disable iff (rst) dc_we |-> (c_we && z_we)); // R4
  AST_SKIP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst) skip_req |-> !(c_we || dc_we || z_we)); // R7
  AST_IMM_TO_ACC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[13:12] == 2'b00) |=> !reg_we); // R9
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ret_pulse, sleep_pulse, wdt_clr_pulse, mode_ld_pulse, dir_ld_pulse})); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(acc_we || reg_we || skip_req || c_we || dc_we || z_we)); // R13

endmodule

// File: tb/acc_exec_unit_tb_top.sv
module acc_exec_unit_tb_top;

  typedef struct packed {
    logic [13:0] ins;
    logic [7:0]  r;
    logic [7:0]  a;
    logic        ci;
    logic [7:0]  res;
    logic [1:0]  we;    // {acc, reg}
    logic [2:0]  fl;    // {c, dc, z}
    logic [2:0]  en;    // {c, dc, z} enables
    logic        skp;
    logic [4:0]  strb;  // {ret, sleep, wdt, mode, dir}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VT [NV] = '{
    '{14'b01_0101_0_0000110, 8'h3A, 8'h08, 1'b0, 8'h42, 2'b10, 3'b010, 3'b111, 1'b0, 5'b0, 4'd4},  // R4
    '{14'b01_0101_1_0000110, 8'hF0, 8'h10, 1'b0, 8'h00, 2'b01, 3'b101, 3'b111, 1'b0, 5'b0, 4'd4},  // R4 R2
    '{14'b01_1010_0_0000110, 8'h05, 8'h03, 1'b0, 8'h02, 2'b10, 3'b110, 3'b111, 1'b0, 5'b0, 4'd3},  // R3
    '{14'b01_1010_1_0000110, 8'h10, 8'h01, 1'b0, 8'h0F, 2'b01, 3'b100, 3'b111, 1'b0, 5'b0, 4'd3},  // R3
    '{14'b01_1010_0_0000110, 8'h02, 8'h05, 1'b0, 8'hFD, 2'b10, 3'b000, 3'b111, 1'b0, 5'b0, 4'd3},  // R3
    '{14'b01_1010_1_0000110, 8'h44, 8'h44, 1'b0, 8'h00, 2'b01, 3'b111, 3'b111, 1'b0, 5'b0, 4'd3},  // R3
    '{14'b01_0100_0_0000110, 8'hF0, 8'h0F, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_1111_1_0000110, 8'h50, 8'h05, 1'b0, 8'h55, 2'b01, 3'b000, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_1011_0_0000110, 8'hAA, 8'hAA, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_0010_1_0000110, 8'hFF, 8'h00, 1'b0, 8'h00, 2'b01, 3'b001, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_1000_0_0000110, 8'hFF, 8'h00, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_0110_1_0000110, 8'h01, 8'h00, 1'b0, 8'h00, 2'b01, 3'b001, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_1110_0_0000110, 8'h3C, 8'h00, 1'b0, 8'hC3, 2'b10, 3'b000, 3'b000, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_0011_0_0000110, 8'h00, 8'h99, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd5},  // R5
    '{14'b01_1100_1_0000110, 8'h81, 8'h00, 1'b0, 8'h40, 2'b01, 3'b100, 3'b100, 1'b0, 5'b0, 4'd6},  // R6
    '{14'b01_1101_0_0000110, 8'h81, 8'h00, 1'b1, 8'h03, 2'b10, 3'b100, 3'b100, 1'b0, 5'b0, 4'd6},  // R6
    '{14'b01_1100_0_0000110, 8'h02, 8'h00, 1'b1, 8'h81, 2'b10, 3'b000, 3'b100, 1'b0, 5'b0, 4'd6},  // R6
    '{14'b01_1001_1_0000110, 8'hFF, 8'h00, 1'b0, 8'h00, 2'b01, 3'b000, 3'b000, 1'b1, 5'b0, 4'd7},  // R7
    '{14'b01_0111_0_0000110, 8'h05, 8'h00, 1'b0, 8'h04, 2'b10, 3'b000, 3'b000, 1'b0, 5'b0, 4'd7},  // R7
    '{14'b01_0111_1_0000110, 8'h01, 8'h00, 1'b0, 8'h00, 2'b01, 3'b000, 3'b000, 1'b1, 5'b0, 4'd7},  // R7
    '{14'b11_10_011_0000110, 8'h00, 8'h00, 1'b0, 8'h08, 2'b01, 3'b000, 3'b000, 1'b0, 5'b0, 4'd8},  // R8
    '{14'b11_11_111_0000110, 8'hFF, 8'h00, 1'b0, 8'h7F, 2'b01, 3'b000, 3'b000, 1'b0, 5'b0, 4'd8},  // R8
    '{14'b11_00_000_0000110, 8'h01, 8'h00, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b1, 5'b0, 4'd8},  // R8
    '{14'b11_00_110_0000110, 8'hBF, 8'h00, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd8},  // R8
    '{14'b11_01_000_0000110, 8'h01, 8'h00, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd8},  // R8
    '{14'b11_01_101_0000110, 8'h00, 8'h00, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b1, 5'b0, 4'd8},  // R8
    '{14'b00_1001_00111100,  8'hFF, 8'hF0, 1'b0, 8'h30, 2'b10, 3'b000, 3'b001, 1'b0, 5'b0, 4'd9},  // R9
    '{14'b00_1000_11111111,  8'h00, 8'hFF, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd9},  // R9
    '{14'b00_0011_00000000,  8'hFF, 8'h00, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd9},  // R9
    '{14'b00_0001_00000000,  8'h55, 8'h77, 1'b0, 8'h00, 2'b10, 3'b000, 3'b000, 1'b0, 5'b0, 4'd9},  // R9
    '{14'b00_1100_01011010,  8'hFF, 8'h00, 1'b0, 8'h5A, 2'b10, 3'b000, 3'b000, 1'b0, 5'b10000, 4'd9},  // R9
    '{14'b01_0001_0_0000000, 8'h12, 8'h55, 1'b0, 8'h00, 2'b10, 3'b001, 3'b001, 1'b0, 5'b0, 4'd10}, // R10
    '{14'b01_0001_1_0000110, 8'h77, 8'h55, 1'b0, 8'h00, 2'b01, 3'b001, 3'b001, 1'b0, 5'b0, 4'd10}, // R10
    '{14'b01_0000_1_0000110, 8'h11, 8'h9C, 1'b0, 8'h9C, 2'b01, 3'b000, 3'b000, 1'b0, 5'b0, 4'd10}, // R10
    '{14'b01_0000_0_0000000, 8'hFF, 8'hFF, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd11}, // R11
    '{14'b01_0000_0_0000001, 8'hFF, 8'hFF, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b00100, 4'd11}, // R11
    '{14'b01_0000_0_0000010, 8'hFF, 8'hFF, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b01000, 4'd11}, // R11
    '{14'b01_0000_0_0000011, 8'hFF, 8'h2B, 1'b0, 8'h2B, 2'b00, 3'b000, 3'b000, 1'b0, 5'b00010, 4'd11}, // R11
    '{14'b01_0000_0_0000110, 8'hFF, 8'h0F, 1'b0, 8'h0F, 2'b00, 3'b000, 3'b000, 1'b0, 5'b00001, 4'd11}, // R11
    '{14'b01_0000_0_0000100, 8'h00, 8'h0F, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd12}, // R12
    '{14'b01_0001_0_0000101, 8'h00, 8'h0F, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd12}, // R12
    '{14'b10_0000_00000000,  8'h00, 8'h00, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd12}, // R12
    '{14'b00_0111_00001111,  8'h00, 8'h00, 1'b0, 8'h00, 2'b00, 3'b000, 3'b000, 1'b0, 5'b0, 4'd12}  // R12
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [13:0] instr;
  logic [7:0]  reg_val, acc_val, result;
  logic        carry_in;
  logic        acc_we, reg_we, c_out, dc_out, z_out, c_we, dc_we, z_we, skip_req;
  logic        ret_pulse, sleep_pulse, wdt_clr_pulse, mode_ld_pulse, dir_ld_pulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  acc_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .reg_val(reg_val), .acc_val(acc_val), .carry_in(carry_in),
    .result(result), .acc_we(acc_we), .reg_we(reg_we),
    .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
    .c_we(c_we), .dc_we(dc_we), .z_we(z_we), .skip_req(skip_req),
    .ret_pulse(ret_pulse), .sleep_pulse(sleep_pulse), .wdt_clr_pulse(wdt_clr_pulse),
    .mode_ld_pulse(mode_ld_pulse), .dir_ld_pulse(dir_ld_pulse)
  );

  function automatic logic [21:0] observed();
    return {result, acc_we, reg_we, c_out, dc_out, z_out, c_we, dc_we, z_we, skip_req,
            ret_pulse, sleep_pulse, wdt_clr_pulse, mode_ld_pulse, dir_ld_pulse};
  endfunction

  task automatic check(input string tag, input logic [21:0] exp);
    logic [21:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [13:0] i, input logic [7:0] r, input logic [7:0] a,
                       input logic ci, input logic v);
    @(negedge clk);
    instr    = i;
    reg_val  = r;
    acc_val  = a;
    carry_in = ci;
    in_valid = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; instr = 14'b01_0101_0_0000110;
    reg_val = 8'hFF; acc_val = 8'h01; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset with valid add", 22'h0);
    rst = 1'b0;
    in_valid = 1'b0;

    for (int k = 0; k < NV; k++) begin
      issue(VT[k].ins, VT[k].r, VT[k].a, VT[k].ci, 1'b1);
      check($sformatf("R%0d vector %0d", VT[k].req, k),
            {VT[k].res, VT[k].we, VT[k].fl, VT[k].en, VT[k].skp, VT[k].strb});
    end

    // R13: skip is a one-cycle pulse; a write and a skip share one cycle (R7)
    issue(14'b01_1001_0_0000110, 8'hFF, 8'h00, 1'b0, 1'b1);
    check("R7 incsz to acc skip+write", {8'h00, 2'b10, 3'b000, 3'b000, 1'b1, 5'b0});
    issue(14'b01_1001_0_0000110, 8'hFF, 8'h00, 1'b0, 1'b0);
    check("R13 skip dropped when idle", 22'h0);

    // R13: idle cycle after a flag-setting op yields quiet outputs
    issue(14'b01_1010_1_0000110, 8'h44, 8'h44, 1'b0, 1'b1);
    issue(14'b01_1010_1_0000110, 8'h44, 8'h44, 1'b0, 1'b0);
    check("R13 idle after sub", 22'h0);

    // R9: register operand ignored for immediate AND
    issue(14'b00_1001_00001111, 8'h00, 8'hF3, 1'b0, 1'b1);
    check("R9 imm and ignores reg", {8'h03, 2'b10, 3'b000, 3'b001, 1'b0, 5'b0});

    // R1: reset mid-run clears a live result
    @(negedge clk);
    instr = 14'b01_0101_0_0000110; reg_val = 8'hFF; acc_val = 8'h01; in_valid = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid-run", 22'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule